// File: doc/BRIEF.md
# Byte-Serial FSM Stream Cipher

This core turns a byte stream into ciphertext, or back again, one byte per handshake. Its state is a wide register, 100 bits by default. A fixed pseudo-random Boolean network moves that register forward once for every accepted byte. Each step mixes in the current state, the cleartext byte and one byte of a repeating secret key. The outgoing byte is the incoming byte XORed with eight fixed bits of the state as they stood before the step.

The same core serves both directions. In decrypt mode it first recovers the cleartext with the same XOR. It then feeds that recovered cleartext, not the ciphertext, into the state network. An encrypting instance and a decrypting instance that start from reset with the same key therefore pass through the same sequence of states. The key itself is held outside the core. The core publishes the index of the key byte it wants next, and it expects that key byte on `key_byte` in the same cycle.

The wiring of the network is fixed at elaboration. It comes from a constant seed through an LFSR-based generator in the package, so every instance built with the same parameters computes the same cipher.

Top module: `fsm_cipher`

## Requirements
- R1: One clock edge after synchronous reset is released, `out_valid` is 0, `key_idx` is 0 and `in_ready` is 1. The state holds the same fixed nonzero value after every reset.
- R2: For an accepted byte, `out_data` equals `in_data` XOR a byte made of eight fixed state bits taken before the step. From reset, therefore, `out_data XOR in_data` of the first byte is one constant for all 256 input values.
- R3: Decrypt mode is `mode_decrypt` = 1 and encrypt mode is 0. A stream encrypted by one instance and decrypted by a second instance, both started from reset with the same key, comes back exactly.
- R4: `key_idx` advances by one on every accepted byte and wraps from KEY_BYTES-1 to 0. The key byte used for a step is the `key_byte` presented while that byte is accepted.
- R5: While no byte is accepted, the state and `key_idx` hold. A stalled stream that resumes produces the same ciphertext as an unstalled one.
- R6: A byte is accepted when `in_valid` and `in_ready` are both 1, where `in_ready` = !`out_valid` or `out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold.
- R7: A single flipped key bit changes roughly half of the keystream bits seen from the ninth byte onward, between 30% and 70% of them.
- R8: A single flipped cleartext bit in the first byte changes roughly half of the keystream bits seen from the ninth byte onward, between 30% and 70% of them.
- R9: After the round trip of R3, both instances are in the same state. Fed the same bytes in encrypt mode, they then give identical output.
- R10: The cipher is deterministic. The same key and cleartext after reset always give the same ciphertext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_decrypt | input | 1 | 0 encrypts, 1 decrypts; sampled with each accepted byte |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Core can accept a byte this cycle |
| in_data | input | 8 | Cleartext (encrypt) or ciphertext (decrypt) byte |
| key_byte | input | 8 | Key byte selected by `key_idx` |
| key_idx | output | KIW | Index of the key byte used by the next step |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Ciphertext (encrypt) or cleartext (decrypt) byte |

## Verification
A wrong state bit in this core stays hidden until the mixing network carries it into one of the eight output taps. After that, every later output byte is corrupted. A fault in the tap selection or in the feedback path shows up on the first byte or within a few bytes. A fault in a part of the network far from the taps can take several steps to reach the output. For that reason, the round-trip and lockstep checks run for tens of bytes. A decryptor that fed ciphertext instead of recovered cleartext into its state would go wrong from the second byte. A stall that leaks a step would shift every later byte.

// File: rtl/fsmc_pkg.sv
package fsmc_pkg;

    localparam logic [31:0] GALOIS_POLY = 32'hD000_0001;

    // Galois LFSR walked a fixed number of steps
    function automatic logic [31:0] lfsr_walk(input logic [31:0] start, input int steps);
        logic [31:0] s;
        s = (start == 32'd0) ? 32'd1 : start;
        for (int k = 0; k < steps; k++) begin
            s = s[0] ? ((s >> 1) ^ GALOIS_POLY) : (s >> 1);
        end
        return s;
    endfunction

    // Pseudo-random word for coordinate (a, b) under a seed
    function automatic logic [31:0] draw(input logic [31:0] seed, input int a, input int b);
        logic [31:0] s;
        logic [31:0] v;
        s = seed ^ (32'(a) * 32'h9E37_79B9) ^ (32'(b) * 32'h85EB_CA6B);
        v = lfsr_walk(s, 37);
        v = v * 32'h2545_F491;
        v = v ^ (v >> 15);
        return v;
    endfunction

    // Source index of input j of next-state bit i.
    // Sources: [0, ms) state, [ms, ms+8) cleartext, [ms+8, ms+16) key.
    function automatic int src_of(input logic [31:0] seed, input int i, input int j, input int ms);
        if (j == 0) return ms + (i % 16);
        if (j == 1) return (i + 1) % ms;
        return int'(draw(seed, i, j) % 32'(ms + 16));
    endfunction

    // Truth table of the nonlinear part of bit i (up to 128 entries)
    function automatic logic [127:0] lut_of(input logic [31:0] seed, input int i);
        return {draw(seed, i, 100), draw(seed, i, 101), draw(seed, i, 102), draw(seed, i, 103)};
    endfunction

    // State bit feeding output tap k
    function automatic int tap_of(input int k, input int ms);
        return (k * ms) / 8 + (ms / 16);
    endfunction

endpackage

// File: rtl/fsmc_mix.sv
module fsmc_mix #(
    parameter int          MS   = 100,
    parameter int          NIN  = 6,
    parameter logic [31:0] SEED = 32'h5EED_C0DE
) (
    input  logic [MS-1:0] state_cur,
    input  logic [7:0]    clear_byte,
    input  logic [7:0]    key_byte,
    output logic [MS-1:0] state_nxt
);
    localparam int NSRC = MS + 16;
    localparam int AW   = NIN - 1;
    localparam int LUTW = 1 << AW;

    logic [NSRC-1:0] srcv;
    assign srcv = {key_byte, clear_byte, state_cur};

    for (genvar gi = 0; gi < MS; gi++) begin : g_bit
        localparam int           S0    = fsmc_pkg::src_of(SEED, gi, 0, MS);
        localparam logic [127:0] LFULL = fsmc_pkg::lut_of(SEED, gi);
        localparam logic [LUTW-1:0] LUT = LFULL[LUTW-1:0];
        logic [AW-1:0] addr;
        for (genvar gj = 1; gj < NIN; gj++) begin : g_in
            localparam int SJ = fsmc_pkg::src_of(SEED, gi, gj, MS);
            assign addr[gj-1] = srcv[SJ];
        end
        // linear data term keeps every key/cleartext bit live; LUT adds nonlinearity
        assign state_nxt[gi] = srcv[S0] ^ LUT[addr];
    end
endmodule

// File: rtl/fsmc_keyidx.sv
module fsmc_keyidx #(
    parameter int KEY_BYTES = 16,
    parameter int KIW       = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step,
    output logic [KIW-1:0] idx
);
    localparam logic [KIW-1:0] LAST = KIW'(KEY_BYTES - 1);

    logic [KIW-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (step) idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) idx_q <= '0;
        else     idx_q <= idx_d;
    end

    assign idx = idx_q;

    p_idx_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> idx_q == '0);
    p_idx_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (step && idx_q == LAST) |=> idx_q == '0);
    p_idx_step_r4: assert property (@(posedge clk) disable iff (rst)
        (step && idx_q != LAST) |=> idx_q == $past(idx_q) + 1'b1);
    p_idx_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(idx_q));
endmodule

// File: rtl/fsm_cipher.sv
module fsm_cipher #(
    parameter int          MACHINE_SIZE       = 100,
    parameter int          NUM_INPUTS_PER_BIT = 6,
    parameter int          KEY_BYTES          = 16,
    parameter logic [31:0] SEED               = 32'h5EED_C0DE,
    localparam int         KIW = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mode_decrypt,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [7:0]     in_data,
    input  logic [7:0]     key_byte,
    output logic [KIW-1:0] key_idx,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [7:0]     out_data
);
    localparam int MS = MACHINE_SIZE;

    typedef struct packed {
        logic [MS-1:0] state;
        logic          out_valid;
        logic [7:0]    out_data;
    } regs_t;

    regs_t         r_d, r_q;
    logic [MS-1:0] init_state;
    logic [MS-1:0] state_nxt;
    logic [7:0]    tap;
    logic [7:0]    clear_byte;
    logic          accept;

    // fixed nonzero initial state
    for (genvar gi = 0; gi < MS; gi++) begin : g_init
        localparam logic [31:0] W = fsmc_pkg::draw(SEED, gi, 200);
        assign init_state[gi] = (gi == 0) ? 1'b1 : W[0];
    end

    // eight fixed output taps
    for (genvar gk = 0; gk < 8; gk++) begin : g_tap
        localparam int TI = fsmc_pkg::tap_of(gk, MS);
        assign tap[gk] = r_q.state[TI];
    end

    assign in_ready   = !r_q.out_valid || out_ready;
    assign accept     = in_valid && in_ready;
    assign clear_byte = mode_decrypt ? (in_data ^ tap) : in_data;

    fsmc_mix #(.MS(MS), .NIN(NUM_INPUTS_PER_BIT), .SEED(SEED)) u_mix (
        .state_cur  (r_q.state),
        .clear_byte (clear_byte),
        .key_byte   (key_byte),
        .state_nxt  (state_nxt)
    );

    fsmc_keyidx #(.KEY_BYTES(KEY_BYTES), .KIW(KIW)) u_kidx (
        .clk  (clk),
        .rst  (rst),
        .step (accept),
        .idx  (key_idx)
    );

    always_comb begin
        r_d = r_q;
        if (out_ready) r_d.out_valid = 1'b0;
        if (accept) begin
            r_d.state     = state_nxt;
            r_d.out_valid = 1'b1;
            r_d.out_data  = in_data ^ tap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state     <= init_state;
            r_q.out_valid <= 1'b0;
            r_q.out_data  <= 8'h00;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.out_valid;
    assign out_data  = r_q.out_data;

    p_out_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!r_q.out_valid && r_q.state == init_state));
    p_cipher_xor_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (r_q.out_valid && r_q.out_data == ($past(in_data) ^ $past(tap))));
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(r_q.state));
    p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (r_q.out_valid && !out_ready) |=> (r_q.out_valid && $stable(r_q.out_data)));
    p_state_live_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> r_q.state != '0);
endmodule

// File: tb/tb_fsm_cipher.sv
module tb_fsm_cipher;
    localparam int KB  = 5;
    localparam int KIW = 3;
    localparam int NB  = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    // encryptor
    logic           e_valid = 1'b0, e_oready = 1'b1;
    logic [7:0]     e_data = 8'h00, e_key, e_out;
    logic           e_ready, e_ovalid;
    logic [KIW-1:0] e_kidx;
    // decryptor
    logic           d_valid = 1'b0, d_mode = 1'b1;
    logic [7:0]     d_data = 8'h00, d_key, d_out;
    logic           d_ready, d_ovalid;
    logic [KIW-1:0] d_kidx;

    logic [7:0] key_mem [KB];
    assign e_key = key_mem[e_kidx];
    assign d_key = key_mem[d_kidx];

    fsm_cipher #(.KEY_BYTES(KB)) dut (
        .clk(clk), .rst(rst), .mode_decrypt(1'b0),
        .in_valid(e_valid), .in_ready(e_ready), .in_data(e_data),
        .key_byte(e_key), .key_idx(e_kidx),
        .out_valid(e_ovalid), .out_ready(e_oready), .out_data(e_out));

    fsm_cipher #(.KEY_BYTES(KB)) dut_dec (
        .clk(clk), .rst(rst), .mode_decrypt(d_mode),
        .in_valid(d_valid), .in_ready(d_ready), .in_data(d_data),
        .key_byte(d_key), .key_idx(d_kidx),
        .out_valid(d_ovalid), .out_ready(1'b1), .out_data(d_out));

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    logic [7:0] msg [NB];
    logic [7:0] ct  [NB];
    logic [7:0] ks_a [40];
    logic [7:0] ks_b [40];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; e_valid = 1'b0; d_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic enc(input logic [7:0] d, output logic [7:0] c);
        @(negedge clk);
        e_valid = 1'b1; e_data = d;
        @(negedge clk);
        c = e_out;
        e_valid = 1'b0;
    endtask

    task automatic dec(input logic [7:0] d, output logic [7:0] c);
        @(negedge clk);
        d_valid = 1'b1; d_data = d;
        @(negedge clk);
        c = d_out;
        d_valid = 1'b0;
    endtask

    task automatic both(input logic [7:0] d, output logic [7:0] ce, output logic [7:0] cd);
        @(negedge clk);
        e_valid = 1'b1; e_data = d; d_valid = 1'b1; d_data = d;
        @(negedge clk);
        ce = e_out; cd = d_out;
        e_valid = 1'b0; d_valid = 1'b0;
    endtask

    task automatic key_default();
        for (int k = 0; k < KB; k++) key_mem[k] = 8'(8'h3A + k * 8'h51);
    endtask

    // 40 bytes of keystream from the encryptor given a first cleartext byte
    task automatic stream40(input logic [7:0] first, output logic [7:0] ks [40]);
        logic [7:0] c;
        do_reset();
        for (int n = 0; n < 40; n++) begin
            enc((n == 0) ? first : 8'h00, c);
            ks[n] = c;
        end
    endtask

    function automatic int diffbits(input logic [7:0] a [40], input logic [7:0] b [40]);
        int s = 0;
        for (int n = 8; n < 40; n++) s += $countones(a[n] ^ b[n]);
        return s;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] c, c2, base;
        logic [31:0] lf;
        int dbits;
        key_default();

        // R1: reset state
        do_reset();
        chk(e_ovalid == 1'b0, "R1 out_valid", int'(e_ovalid), 0);
        chk(e_kidx == '0, "R1 key_idx", int'(e_kidx), 0);
        chk(e_ready == 1'b1, "R1 in_ready", int'(e_ready), 1);

        // R2: exhaustive sweep of first byte, mask is constant
        base = 8'h00;
        for (int x = 0; x < 256; x++) begin
            do_reset();
            enc(8'(x), c);
            if (x == 0) base = c;
            chk((c ^ 8'(x)) == base, "R2 first-byte mask", int'(c ^ 8'(x)), int'(base));
        end

        // message from a bench LFSR
        lf = 32'h1234_5678;
        for (int n = 0; n < NB; n++) begin
            lf = lf[0] ? ((lf >> 1) ^ 32'h8020_0003) : (lf >> 1);
            msg[n] = lf[7:0] ^ lf[23:16];
        end

        // R3, R4: encrypt, tracking key index
        do_reset();
        for (int n = 0; n < NB; n++) begin
            enc(msg[n], c);
            ct[n] = c;
            chk(e_kidx == KIW'((n + 1) % KB), "R4 key_idx step/wrap", int'(e_kidx), (n + 1) % KB);
        end
        // decrypt on second instance (not reset in between: it idled)
        d_mode = 1'b1;
        for (int n = 0; n < NB; n++) begin
            dec(ct[n], c);
            chk(c == msg[n], "R3 round trip", int'(c), int'(msg[n]));
        end

        // R9: lockstep after round trip
        d_mode = 1'b0;
        for (int n = 0; n < 24; n++) begin
            both(8'(n * 13), c, c2);
            chk(c == c2, "R9 lockstep", int'(c2), int'(c));
        end
        d_mode = 1'b1;

        // R10: rerun gives same ciphertext
        do_reset();
        for (int n = 0; n < 16; n++) begin
            enc(msg[n], c);
            chk(c == ct[n], "R10 determinism", int'(c), int'(ct[n]));
        end

        // R5, R6: stall with output back-pressure
        do_reset();
        @(negedge clk);
        e_oready = 1'b0; e_valid = 1'b1; e_data = msg[0];
        @(negedge clk);
        e_data = msg[1];
        for (int k = 0; k < 4; k++) begin
            chk(e_ready == 1'b0, "R6 in_ready low", int'(e_ready), 0);
            chk(e_ovalid == 1'b1 && e_out == ct[0], "R6 output held", int'(e_out), int'(ct[0]));
            chk(e_kidx == KIW'(1), "R5 key_idx held", int'(e_kidx), 1);
            @(negedge clk);
        end
        e_oready = 1'b1;
        @(negedge clk);
        e_valid = 1'b0;
        chk(e_out == ct[1], "R5 resume ciphertext", int'(e_out), int'(ct[1]));
        chk(e_kidx == KIW'(2), "R5 key_idx after resume", int'(e_kidx), 2);
        enc(msg[2], c);
        chk(c == ct[2], "R5 state held through stall", int'(c), int'(ct[2]));

        // R7: key bit flip diffusion
        stream40(8'h00, ks_a);
        key_mem[0] = key_mem[0] ^ 8'h04;
        stream40(8'h00, ks_b);
        key_default();
        dbits = diffbits(ks_a, ks_b);
        chk(dbits >= 77 && dbits <= 179, "R7 key diffusion", dbits, 128);

        // R8: cleartext bit flip diffusion
        stream40(8'h01, ks_b);
        dbits = diffbits(ks_a, ks_b);
        chk(dbits >= 77 && dbits <= 179, "R8 cleartext diffusion", dbits, 128);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule